// File: doc/BRIEF.md
# Two-Colour Cursor Overlay Compositor

This block lays a 32x32 pointer image over a stream of display pixels. Software fills two bitmaps through a 32-bit register port. The first is a shape bitmap that says where the pointer is opaque. The second is a colour-choice bitmap that says which of two overlay colours each opaque pixel takes. Software also writes one packed register that places the pointer's top-left corner on the screen.

During scan-out the video pipeline presents one pixel per cycle. Each pixel comes with its line number and column, the active line width, and the colour already resolved by the palette. The two overlay colours arrive as inputs from outside. The block returns either the incoming colour or one of the overlay colours, one cycle later, together with a delayed copy of the pixel-valid flag.

The pointer comes out of reset parked far off screen, so nothing is drawn until software moves it. Palette storage, video timing and frame-memory fetch all lie outside this block.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is held, `pixOut` is 0, `pixOutValid` is 0 and `regRdData` is 0. After reset the pointer sits at X = Y = 0xF000, so every pixel on a screen narrower than 0xF000 passes through, even with the shape bitmap fully set.
- R2: A full-word write to byte offset 0x8FC places the pointer: bits 31:16 give column X and bits 15:0 give line Y.
- R3: A full-word write to offset 0x900 + 4n loads shape row n, and a write to 0x980 + 4n loads colour-choice row n, for n = 0..31.
- R4: Bit 31 of a row covers the pointer pixel at column X, and bit 31-k covers column X+k.
- R5: A pixel whose shape bit is 0 passes `pixIn` unchanged. A pixel whose shape bit is 1 outputs `ovColorHi` when its colour-choice bit is 1, and `ovColorLo` when that bit is 0.
- R6: The pointer covers only lines Y through Y+31, compared unsigned without wrap-around, and the row index is line minus Y. A pointer placed near 0xFFFF never reaches line 0.
- R7: Nothing is drawn when X is not below `activeWidth`. Pointer columns at or beyond `activeWidth` are clipped and pass `pixIn`.
- R8: A full-word write to 0x818 stores a 32-bit scratch word. A read of 0x818 returns that word with bit 25 forced to 1.
- R9: A read of any address other than 0x818 returns 0, including the position and bitmap addresses.
- R10: A write with any byte enable low, or with address bits 1:0 non-zero, changes no state.
- R11: `pixOut` and `pixOutValid` reflect the pixel inputs sampled at the previous rising edge.
- R12: `regRdData` holds the read result during the cycle after a cycle with `regRdEn` high, and is 0 after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 12 | Byte address within the register window |
| regByteEn | input | 4 | Byte enables; only 4'hF is a valid access |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, one cycle after the read strobe |
| lineNum | input | 16 | Current scan line |
| pixCol | input | 16 | Current pixel column |
| activeWidth | input | 16 | Visible pixels per line |
| pixValid | input | 1 | Pixel inputs carry an active pixel |
| pixIn | input | 24 | Palette-resolved pixel colour |
| ovColorLo | input | 24 | Overlay colour for colour-choice bit 0 |
| ovColorHi | input | 24 | Overlay colour for colour-choice bit 1 |
| pixOut | output | 24 | Composited pixel |
| pixOutValid | output | 1 | Delayed pixel-valid flag |

## Verification
The hardest cases to reach from the ports are the edges of the pointer window. These are the right-hand clip where the pointer straddles `activeWidth`, and the unsigned no-wrap case where Y lies just below 0xFFFF. Both require a full position write before the pixels are streamed.

The stimulus loads distinct bitmaps in every row, with single-bit markers in the first and last rows. It then sweeps pixel coordinates across each window edge: just outside, first covered pixel, last covered pixel, and clipped columns. Partial-enable writes are followed at once by a pixel sweep or a read, so that any state they wrongly touched becomes visible.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int CUR_DIM = 32;
  localparam int ROW_W = $clog2(CUR_DIM);
  localparam int REG_ADDR_W = 12;
  localparam int REG_DATA_W = 32;

  localparam logic [REG_ADDR_W-1:0] MISC_OFFSET = 12'h818;
  localparam logic [REG_ADDR_W-1:0] POS_OFFSET = 12'h8FC;
  localparam logic [REG_ADDR_W-1:0] SHAPE_BASE = 12'h900;
  localparam logic [REG_ADDR_W-1:0] SHAPE_END = 12'h980;
  localparam logic [REG_ADDR_W-1:0] CHOICE_BASE = 12'h980;
  localparam logic [REG_ADDR_W-1:0] CHOICE_END = 12'hA00;
  localparam logic [REG_DATA_W-1:0] MISC_FORCED = 32'h0200_0000;

  typedef struct packed {
    logic posWr;
    logic shapeWr;
    logic choiceWr;
    logic miscWr;
    logic miscRd;
    logic [ROW_W-1:0] row;
  } ctrlStrobe_t;
endpackage

// File: rtl/cursor_ctrl.sv
module cursor_ctrl
  import cursor_pkg::*;
(
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [3:0]            regByteEn,
  output ctrlStrobe_t           strobe
);
  logic fullWord;
  logic inShape;
  logic inChoice;
  logic wrOk;

  // Only aligned, all-bytes accesses count as valid.
  assign fullWord = (&regByteEn) && (regAddr[1:0] == 2'b00);
  assign wrOk = regWrEn && fullWord;
  assign inShape = (regAddr >= SHAPE_BASE) && (regAddr < SHAPE_END);
  assign inChoice = (regAddr >= CHOICE_BASE) && (regAddr < CHOICE_END);

  always_comb begin
    strobe.posWr = wrOk && (regAddr == POS_OFFSET);
    strobe.shapeWr = wrOk && inShape;
    strobe.choiceWr = wrOk && inChoice;
    strobe.miscWr = wrOk && (regAddr == MISC_OFFSET);
    strobe.miscRd = regRdEn && fullWord && (regAddr == MISC_OFFSET);
    strobe.row = regAddr[ROW_W+1:2];
  end
endmodule

// File: rtl/cursor_datapath.sv
module cursor_datapath
  import cursor_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int COLOR_W = 24,
  parameter logic [COORD_W-1:0] PARK_POS = 16'hF000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [REG_DATA_W-1:0] regWrData,
  output logic [REG_DATA_W-1:0] regRdData,
  input  logic [COORD_W-1:0]    lineNum,
  input  logic [COORD_W-1:0]    pixCol,
  input  logic [COORD_W-1:0]    activeWidth,
  input  logic                  pixValid,
  input  logic [COLOR_W-1:0]    pixIn,
  input  logic [COLOR_W-1:0]    ovColorLo,
  input  logic [COLOR_W-1:0]    ovColorHi,
  output logic [COLOR_W-1:0]    pixOut,
  output logic                  pixOutValid,
  output logic [COORD_W-1:0]    curX,
  output logic [COORD_W-1:0]    curY
);
  localparam logic [COORD_W-1:0] DIM_C = COORD_W'(CUR_DIM);
  localparam logic [ROW_W-1:0] LAST_BIT = ROW_W'(CUR_DIM - 1);

  logic [CUR_DIM-1:0] shapeMem [CUR_DIM];
  logic [CUR_DIM-1:0] choiceMem [CUR_DIM];
  logic [REG_DATA_W-1:0] miscReg;

  // Position and scratch registers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curX <= PARK_POS;
      curY <= PARK_POS;
      miscReg <= '0;
    end else begin
      if (strobe.posWr) begin
        curX <= regWrData[2*COORD_W-1:COORD_W];
        curY <= regWrData[COORD_W-1:0];
      end
      if (strobe.miscWr) miscReg <= regWrData;
    end
  end

  // One storage row per pointer line.
  for (genvar g = 0; g < CUR_DIM; g++) begin : gRow
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shapeMem[g] <= '0;
        choiceMem[g] <= '0;
      end else begin
        if (strobe.shapeWr && (strobe.row == ROW_W'(g))) shapeMem[g] <= regWrData;
        if (strobe.choiceWr && (strobe.row == ROW_W'(g))) choiceMem[g] <= regWrData;
      end
    end
  end

  // Read port: only the scratch word is visible.
  always_ff @(posedge clk) begin
    if (!rstN) regRdData <= '0;
    else if (strobe.miscRd) regRdData <= miscReg | MISC_FORCED;
    else regRdData <= '0;
  end

  // Hit test, all unsigned and without wrap-around.
  logic [COORD_W-1:0] rowOff;
  logic [COORD_W-1:0] colOff;
  logic inRows;
  logic inCols;
  logic xShown;
  logic colShown;
  logic [ROW_W-1:0] rowIdx;
  logic [ROW_W-1:0] bitIdx;
  logic shapeBit;
  logic choiceBit;
  logic hit;
  logic [COLOR_W-1:0] mixed;

  always_comb begin
    rowOff = lineNum - curY;
    colOff = pixCol - curX;
    inRows = (lineNum >= curY) && (rowOff < DIM_C);
    inCols = (pixCol >= curX) && (colOff < DIM_C);
    xShown = curX < activeWidth;
    colShown = pixCol < activeWidth;
    rowIdx = rowOff[ROW_W-1:0];
    bitIdx = LAST_BIT - colOff[ROW_W-1:0];
    shapeBit = shapeMem[rowIdx][bitIdx];
    choiceBit = choiceMem[rowIdx][bitIdx];
    hit = inRows && inCols && xShown && colShown && shapeBit;
    if (hit) mixed = choiceBit ? ovColorHi : ovColorLo;
    else mixed = pixIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixOut <= '0;
      pixOutValid <= 1'b0;
    end else begin
      pixOut <= mixed;
      pixOutValid <= pixValid;
    end
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int COLOR_W = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [3:0]            regByteEn,
  input  logic [REG_DATA_W-1:0] regWrData,
  output logic [REG_DATA_W-1:0] regRdData,
  input  logic [COORD_W-1:0]    lineNum,
  input  logic [COORD_W-1:0]    pixCol,
  input  logic [COORD_W-1:0]    activeWidth,
  input  logic                  pixValid,
  input  logic [COLOR_W-1:0]    pixIn,
  input  logic [COLOR_W-1:0]    ovColorLo,
  input  logic [COLOR_W-1:0]    ovColorHi,
  output logic [COLOR_W-1:0]    pixOut,
  output logic                  pixOutValid
);
  ctrlStrobe_t strobe;
  logic [COORD_W-1:0] curX;
  logic [COORD_W-1:0] curY;

  cursor_ctrl uCtrl (
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regByteEn (regByteEn),
    .strobe    (strobe)
  );

  cursor_datapath #(
    .COORD_W (COORD_W),
    .COLOR_W (COLOR_W)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .lineNum     (lineNum),
    .pixCol      (pixCol),
    .activeWidth (activeWidth),
    .pixValid    (pixValid),
    .pixIn       (pixIn),
    .ovColorLo   (ovColorLo),
    .ovColorHi   (ovColorHi),
    .pixOut      (pixOut),
    .pixOutValid (pixOutValid),
    .curX        (curX),
    .curY        (curY)
  );
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk
  import cursor_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int COLOR_W = 24
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  regRdEn,
  input logic [REG_ADDR_W-1:0] regAddr,
  input logic [3:0]            regByteEn,
  input logic [REG_DATA_W-1:0] regRdData,
  input logic [COORD_W-1:0]    lineNum,
  input logic [COORD_W-1:0]    pixCol,
  input logic [COORD_W-1:0]    activeWidth,
  input logic                  pixValid,
  input logic [COLOR_W-1:0]    pixIn,
  input logic [COLOR_W-1:0]    pixOut,
  input logic                  pixOutValid,
  input logic [COORD_W-1:0]    curX,
  input logic [COORD_W-1:0]    curY
);
  localparam logic [COORD_W-1:0] DIM_C = COORD_W'(CUR_DIM);

  // R11
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> pixOutValid);

  // R11
  valid_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> !pixOutValid);

  // R6
  outside_rows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineNum < curY || (lineNum - curY) >= DIM_C) |=> pixOut == $past(pixIn));

  // R7
  clip_cols_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixCol >= activeWidth || curX >= activeWidth) |=> pixOut == $past(pixIn));

  // R12
  idle_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> regRdData == '0);

  // R8
  forced_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && (&regByteEn) && regAddr == MISC_OFFSET) |=> regRdData[25]);
endmodule

bind cursor_overlay cursor_overlay_chk #(.COORD_W(COORD_W), .COLOR_W(COLOR_W)) uChk (.*);

// File: tb/cursor_overlay_test.sv
`timescale 1ns/1ps
module cursor_overlay_test;
  localparam logic [23:0] COL_LO = 24'h10_20_30;
  localparam logic [23:0] COL_HI = 24'hE0_D0_C0;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN;
  logic regWrEn, regRdEn;
  logic [11:0] regAddr;
  logic [3:0] regByteEn;
  logic [31:0] regWrData, regRdData;
  logic [15:0] lineNum, pixCol, activeWidth;
  logic pixValid;
  logic [23:0] pixIn, pixOut;
  logic pixOutValid;

  cursor_overlay uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regByteEn(regByteEn), .regWrData(regWrData),
    .regRdData(regRdData), .lineNum(lineNum), .pixCol(pixCol),
    .activeWidth(activeWidth), .pixValid(pixValid), .pixIn(pixIn),
    .ovColorLo(COL_LO), .ovColorHi(COL_HI), .pixOut(pixOut),
    .pixOutValid(pixOutValid)
  );

  int testsRun = 0;
  int testsFailed = 0;

  typedef struct {
    logic [23:0] exp;
    string tag;
  } expItem_t;
  expItem_t scoreQ[$];

  // Bench model of the programmed state.
  logic [31:0] mShape [32];
  logic [31:0] mChoice [32];
  int mX = 'hF000;
  int mY = 'hF000;
  int mWidth = 640;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] expPix(int line, int col, logic [23:0] pix);
    int r, b;
    if (line >= mY && line < mY + 32 && mX < mWidth && col < mWidth &&
        col >= mX && col < mX + 32) begin
      r = line - mY;
      b = 31 - (col - mX);
      if (mShape[r][b]) return mChoice[r][b] ? COL_HI : COL_LO;
    end
    return pix;
  endfunction

  task automatic regWrite(input int addr, input logic [31:0] data, input logic [3:0] be);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 12'(addr); regWrData = data; regByteEn = be;
    @(negedge clk);
    regWrEn = 1'b0; regByteEn = 4'hF;
    if (be == 4'hF && addr[1:0] == 2'b00) begin
      if (addr == 'h8FC) begin
        mX = int'(data[31:16]);
        mY = int'(data[15:0]);
      end else if (addr >= 'h900 && addr < 'h980) mShape[(addr - 'h900) / 4] = data;
      else if (addr >= 'h980 && addr < 'hA00) mChoice[(addr - 'h980) / 4] = data;
    end
  endtask

  task automatic regRead(input int addr, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = 12'(addr); regByteEn = 4'hF;
    @(negedge clk);
    regRdEn = 1'b0;
    check(regRdData == exp, tag, regRdData, exp);
  endtask

  task automatic pixel(input int line, input int col, input string tag);
    logic [23:0] p;
    p = 24'(32'h00A0_0000 + line * 37 + col * 11);
    @(negedge clk);
    pixValid = 1'b1; lineNum = 16'(line); pixCol = 16'(col);
    activeWidth = 16'(mWidth); pixIn = p;
    scoreQ.push_back('{exp: expPix(line, col, p), tag: tag});
  endtask

  task automatic idleCheck(input string tag);
    @(negedge clk);
    pixValid = 1'b0;
    @(negedge clk);
    check(pixOutValid == 1'b0, tag, 32'(pixOutValid), 32'd0);
  endtask

  task automatic sweep(input int l0, input int l1, input int c0, input int c1, input string tag);
    for (int l = l0; l <= l1; l++)
      for (int c = c0; c <= c1; c++) pixel(l, c, tag);
    @(negedge clk);
    pixValid = 1'b0;
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rstN === 1'b1 && pixOutValid === 1'b1) begin
      if (scoreQ.size() == 0) begin
        check(1'b0, "R11 unexpected output", 32'(pixOut), 32'd0);
      end else begin
        expItem_t it;
        it = scoreQ.pop_front();
        check(pixOut == it.exp, it.tag, 32'(pixOut), 32'(it.exp));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regRdEn = 1'b0; regAddr = '0;
    regByteEn = 4'hF; regWrData = '0; lineNum = '0; pixCol = '0;
    activeWidth = 16'd640; pixValid = 1'b0; pixIn = '0;
    for (int i = 0; i < 32; i++) begin mShape[i] = '0; mChoice[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pixOut == '0, "R1 pixOut in reset", 32'(pixOut), 0);
    check(pixOutValid == 1'b0, "R1 valid in reset", 32'(pixOutValid), 0);
    check(regRdData == '0, "R1 rdData in reset", regRdData, 0);
    rstN = 1'b1;

    // R1 parked pointer: full shape bitmap, nothing drawn
    for (int r = 0; r < 32; r++) begin
      regWrite('h900 + 4 * r, 32'hFFFF_FFFF, 4'hF);
      regWrite('h980 + 4 * r, 32'hFFFF_FFFF, 4'hF);
    end
    sweep(0, 2, 0, 40, "R1 parked passthrough");

    // R3 distinct bitmaps, with markers in rows 0 and 31
    for (int r = 1; r < 31; r++) begin
      regWrite('h900 + 4 * r, 32'hF0F0_F0F0 ^ (32'h0101_0101 * r), 4'hF);
      regWrite('h980 + 4 * r, 32'h3C3C_C3C3 ^ (32'h0001_0003 * r), 4'hF);
    end
    regWrite('h900, 32'h8000_0000, 4'hF);
    regWrite('h980, 32'h8000_0000, 4'hF);
    regWrite('h900 + 124, 32'h0000_0001, 4'hF);
    regWrite('h980 + 124, 32'h0000_0000, 4'hF);

    // R8 / R9 / R12 register reads
    regRead('h818, 32'h0200_0000, "R8 scratch reset read");
    regWrite('h818, 32'h00A5_00FF, 4'hF);
    regRead('h818, 32'h02A5_00FF, "R8 scratch readback");
    regRead('h8FC, 32'h0, "R9 position reads zero");
    regRead('h904, 32'h0, "R9 shape row reads zero");
    @(negedge clk);
    check(regRdData == '0, "R12 idle read data", regRdData, 0);

    // R2 / R4 / R5 / R6 main window
    mWidth = 640;
    regWrite('h8FC, {16'd100, 16'd50}, 4'hF);
    pixel(50, 100, "R4 leftmost pixel hi");
    pixel(50, 101, "R4 next pixel passes");
    pixel(81, 131, "R5 last pixel lo");
    pixel(81, 130, "R5 last row passes");
    @(negedge clk); pixValid = 1'b0;
    sweep(49, 50, 96, 134, "R6 top edge");
    sweep(60, 62, 96, 134, "R5 R2 R3 body rows");
    sweep(81, 82, 96, 134, "R6 bottom edge");

    // R11 gaps between pixels
    pixel(55, 110, "R11 gapped pixel");
    idleCheck("R11 valid drops");
    pixel(56, 111, "R11 gapped pixel");
    idleCheck("R11 valid drops");

    // R7 right clip
    regWrite('h8FC, {16'd620, 16'd10}, 4'hF);
    sweep(10, 10, 615, 660, "R7 first row clip");
    sweep(20, 20, 615, 660, "R7 body clip");
    sweep(41, 41, 615, 660, "R7 last row clipped");
    regWrite('h8FC, {16'd640, 16'd10}, 4'hF);
    sweep(10, 12, 630, 645, "R7 X at width");

    // R10 partial writes
    regWrite('h8FC, {16'd5, 16'd5}, 4'b0111);
    sweep(5, 6, 0, 40, "R10 partial position write");
    regWrite('h8FE, {16'd5, 16'd5}, 4'hF);
    sweep(5, 6, 0, 40, "R10 misaligned write");
    regWrite('h818, 32'h1111_1111, 4'b1110);
    regRead('h818, 32'h02A5_00FF, "R10 partial scratch write");

    // R6 no wrap near the top of the coordinate range
    regWrite('h8FC, {16'd0, 16'hFFF0}, 4'hF);
    sweep(0, 20, 0, 4, "R6 no wrap");
    regWrite('h8FC, {16'd0, 16'd0}, 4'hF);
    sweep(0, 1, 0, 3, "R2 origin placement");

    repeat (4) @(negedge clk);
    check(scoreQ.size() == 0, "R11 outputs drained", scoreQ.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule